// File: doc/BRIEF.md
# Tracked-Address Load Bypass Filter

This block decides, for a load whose address was worked out early in the front end, whether that load may go to the cache ahead of the stores that precede it in program order. Stores go through the same front-end tracking arithmetic as loads. Each store is written into a small in-order queue, tagged with its sequence id and with a flag that says whether its address could be resolved. A store whose address could not be resolved takes a queue slot all the same and acts as a barrier.

Each load query carries an address and a size code. The filter compares the load's byte range with every store held in the queue, and also with a store presented in the same cycle. It returns either a grant or a deny one cycle later. Any overlap with a tracked store denies the load, including a partial overlap. Any untracked store in the queue denies every load. Stores leave the queue oldest first as they retire. A flush discards every store younger than a given sequence id.

The queue is compacted at all times: slot 0 holds the oldest store. Only loads whose own address was resolved early are ever presented. No dependence prediction takes place.

Top module: `early_load_gate`

## Requirements
- R1: After reset the queue is empty, `stReady` is 1, and both `ldGrant` and `ldDeny` are 0.
- R2: For every cycle with `ldVld` high, exactly one of `ldGrant`/`ldDeny` is high in the following cycle. When `ldVld` was low, both are low.
- R3: A size code n means an access of 2^n bytes, starting at the given address. A load is denied if its byte range shares at least one byte with a queued tracked store, including a partial overlap.
- R4: A load whose byte range shares no byte with any queued tracked store, and with no untracked store queued, is granted. Adjacent ranges and an empty queue both give a grant.
- R5: While any untracked store (`stTracked`=0) is queued, every load is denied, whatever its address.
- R6: A store accepted in the same cycle as a load query counts as older than that load.
- R7: `retireVld` removes the oldest queued store, and any barrier or overlap that store formed is released. A retire on an empty queue has no effect.
- R8: `flushVld` removes every queued store whose id is younger than `flushId`. An entry is younger when (id − flushId) mod 2^ID_W is nonzero and below 2^(ID_W−1). Older and equal ids stay. `stReady` is 0 during a flush cycle, and a store presented then is dropped.
- R9: The queue holds DEPTH (8) stores. When it is full, `stReady` is 0 and a presented store is ignored. A query made while the queue is full is checked against all DEPTH entries.
- R10: A query is checked against the entries held at the start of its cycle. A store retired or flushed in that same cycle still takes part in the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stVld | input | 1 | Store presented for insertion |
| stTracked | input | 1 | Store address was resolved early |
| stAddr | input | ADDR_W | Store start address |
| stSize | input | SIZE_W | Store size code (2^n bytes) |
| stId | input | ID_W | Store sequence id |
| stReady | output | 1 | Store will be accepted this cycle |
| retireVld | input | 1 | Oldest store retires |
| flushVld | input | 1 | Discard stores younger than flushId |
| flushId | input | ID_W | Flush point sequence id |
| ldVld | input | 1 | Load query valid |
| ldAddr | input | ADDR_W | Load start address |
| ldSize | input | SIZE_W | Load size code (2^n bytes) |
| ldGrant | output | 1 | Early issue allowed (query of previous cycle) |
| ldDeny | output | 1 | Early issue refused (query of previous cycle) |

## Verification
The grant or deny for a query appears one register stage after the query is presented. The bench therefore drives each query, waits for the next rising edge, and samples 2 ns after that edge, before it drives anything new. `stReady` depends combinationally on the queue count and on the flush input, so the bench samples it 1 ns after driving, within the same cycle. The effect of a retire, flush or store insertion is seen at the ports through a later query. The query in the same cycle checks the requirement that same-cycle retires and flushes still count.

// File: rtl/elg_pkg.sv
package elg_pkg;
  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic push;   // write incoming store into pushSlot
    logic pop;    // drop slot 0 and shift down
    logic flush;  // clear entries younger than flushId
  } elg_strobe_t;
endpackage

// File: rtl/elg_ctrl.sv
module elg_ctrl
  import elg_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SLOT_W = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stVld,
  input  logic              retireVld,
  input  logic              flushVld,
  input  logic              ldVld,
  input  logic [DEPTH-1:0]  validVec,
  input  logic              hitAny,
  output elg_strobe_t       stb,
  output logic [SLOT_W-1:0] pushSlot,
  output logic              stReady,
  output logic              ldGrant,
  output logic              ldDeny
);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] countAfterPop;

  always_comb begin
    count         = CNT_W'($countones(validVec));
    stReady       = (count < CNT_W'(DEPTH)) && !flushVld;
    stb.push      = stVld && stReady;
    stb.pop       = retireVld && (count != '0);
    stb.flush     = flushVld;
    countAfterPop = count - {{(CNT_W-1){1'b0}}, stb.pop};
    pushSlot      = SLOT_W'(countAfterPop);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldGrant <= 1'b0;
      ldDeny  <= 1'b0;
    end else begin
      ldGrant <= ldVld && !hitAny;
      ldDeny  <= ldVld && hitAny;
    end
  end

  assert_resp_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ldGrant, ldDeny}));
  assert_resp_due_R2: assert property (@(posedge clk) disable iff (!rstN)
    ldVld |=> (ldGrant || ldDeny));
  assert_resp_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ldVld |=> !(ldGrant || ldDeny));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> (count < CNT_W'(DEPTH)));
  assert_full_stall_R9: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_W'(DEPTH)) |-> !stReady);
  assert_flush_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    flushVld |-> !stb.push);
  assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (retireVld && validVec == '0 && !stVld) |=> (validVec == '0));

endmodule

// File: rtl/elg_dpath.sv
module elg_dpath
  import elg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 2,
  parameter int ID_W   = 6,
  parameter int DEPTH  = 8,
  parameter int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  elg_strobe_t       stb,
  input  logic [SLOT_W-1:0] pushSlot,
  input  logic              stTracked,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [SIZE_W-1:0] stSize,
  input  logic [ID_W-1:0]   stId,
  input  logic [ID_W-1:0]   flushId,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [SIZE_W-1:0] ldSize,
  output logic [DEPTH-1:0]  validVec,
  output logic [DEPTH-1:0]  untrkVec,
  output logic              hitAny
);

  localparam int EXT_W = ADDR_W + 1;

  // Byte ranges [a, a+2^sa) and [b, b+2^sb) share a byte
  function automatic logic rangesMeet(input logic [ADDR_W-1:0] aAddr,
                                      input logic [SIZE_W-1:0] aSize,
                                      input logic [ADDR_W-1:0] bAddr,
                                      input logic [SIZE_W-1:0] bSize);
    logic [EXT_W-1:0] aLo, aHi, bLo, bHi;
    aLo = {1'b0, aAddr};
    bLo = {1'b0, bAddr};
    aHi = aLo + (EXT_W'(1) << aSize);
    bHi = bLo + (EXT_W'(1) << bSize);
    return (aLo < bHi) && (bLo < aHi);
  endfunction

  logic [ADDR_W-1:0] entAddr [DEPTH];
  logic [SIZE_W-1:0] entSize [DEPTH];
  logic [ID_W-1:0]   entId   [DEPTH];
  logic [DEPTH-1:0]  entVld;
  logic [DEPTH-1:0]  entTrk;
  logic [DEPTH-1:0]  slotHit;
  logic              inHit;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic              vQ, tQ;
    logic [ADDR_W-1:0] aQ;
    logic [SIZE_W-1:0] zQ;
    logic [ID_W-1:0]   iQ;
    logic              shVld, shTrk;
    logic [ADDR_W-1:0] shAddr;
    logic [SIZE_W-1:0] shSize;
    logic [ID_W-1:0]   shId;
    logic [ID_W-1:0]   ageDiff;
    logic              dropIt;
    logic              takeNew;

    // Source of this slot after an optional shift toward slot 0
    if (s == DEPTH - 1) begin : g_top
      assign shVld  = stb.pop ? 1'b0 : entVld[s];
      assign shTrk  = entTrk[s];
      assign shAddr = entAddr[s];
      assign shSize = entSize[s];
      assign shId   = entId[s];
    end else begin : g_mid
      assign shVld  = stb.pop ? entVld[s+1]  : entVld[s];
      assign shTrk  = stb.pop ? entTrk[s+1]  : entTrk[s];
      assign shAddr = stb.pop ? entAddr[s+1] : entAddr[s];
      assign shSize = stb.pop ? entSize[s+1] : entSize[s];
      assign shId   = stb.pop ? entId[s+1]   : entId[s];
    end

    // Younger than the flush point in modular sequence order
    assign ageDiff = shId - flushId;
    assign dropIt  = stb.flush && (ageDiff != '0) && !ageDiff[ID_W-1];
    assign takeNew = stb.push && (pushSlot == SLOT_W'(s));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vQ <= 1'b0;
        tQ <= 1'b0;
        aQ <= '0;
        zQ <= '0;
        iQ <= '0;
      end else if (takeNew) begin
        vQ <= 1'b1;
        tQ <= stTracked;
        aQ <= stAddr;
        zQ <= stSize;
        iQ <= stId;
      end else begin
        vQ <= shVld && !dropIt;
        tQ <= shTrk;
        aQ <= shAddr;
        zQ <= shSize;
        iQ <= shId;
      end
    end

    assign entVld[s]  = vQ;
    assign entTrk[s]  = tQ;
    assign entAddr[s] = aQ;
    assign entSize[s] = zQ;
    assign entId[s]   = iQ;

    assign slotHit[s] = vQ && (!tQ || rangesMeet(aQ, zQ, ldAddr, ldSize));
  end

  // Store accepted this cycle is older than the load of this cycle
  assign inHit    = stb.push && (!stTracked || rangesMeet(stAddr, stSize, ldAddr, ldSize));
  assign hitAny   = (|slotHit) || inHit;
  assign validVec = entVld;
  assign untrkVec = entVld & ~entTrk;

  assert_prefix_R7: assert property (@(posedge clk) disable iff (!rstN)
    (entVld & (entVld + DEPTH'(1))) == '0);
  assert_push_lands_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && !stb.pop) |=> ($countones(entVld) >= 1));

endmodule

// File: rtl/early_load_gate.sv
module early_load_gate
  import elg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 2,
  parameter int ID_W   = 6,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stVld,
  input  logic              stTracked,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [SIZE_W-1:0] stSize,
  input  logic [ID_W-1:0]   stId,
  output logic              stReady,
  input  logic              retireVld,
  input  logic              flushVld,
  input  logic [ID_W-1:0]   flushId,
  input  logic              ldVld,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [SIZE_W-1:0] ldSize,
  output logic              ldGrant,
  output logic              ldDeny
);

  localparam int SLOT_W = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  elg_strobe_t       stb;
  logic [SLOT_W-1:0] pushSlot;
  logic [DEPTH-1:0]  validVec;
  logic [DEPTH-1:0]  untrkVec;
  logic              hitAny;

  elg_ctrl #(.DEPTH(DEPTH), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .stVld(stVld), .retireVld(retireVld),
    .flushVld(flushVld), .ldVld(ldVld), .validVec(validVec), .hitAny(hitAny),
    .stb(stb), .pushSlot(pushSlot), .stReady(stReady),
    .ldGrant(ldGrant), .ldDeny(ldDeny)
  );

  elg_dpath #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .ID_W(ID_W), .DEPTH(DEPTH),
              .SLOT_W(SLOT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pushSlot(pushSlot),
    .stTracked(stTracked), .stAddr(stAddr), .stSize(stSize), .stId(stId),
    .flushId(flushId), .ldAddr(ldAddr), .ldSize(ldSize),
    .validVec(validVec), .untrkVec(untrkVec), .hitAny(hitAny)
  );

  assert_barrier_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ldVld && (untrkVec != '0)) |=> ldDeny);
  assert_empty_grant_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ldVld && validVec == '0 && !stVld) |=> ldGrant);
  assert_same_cycle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ldVld && stVld && stReady && !stTracked) |=> ldDeny);

endmodule

// File: tb/early_load_gate_tb_top.sv
`timescale 1ns/1ps
module early_load_gate_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stVld = 0, stTracked = 0, retireVld = 0, flushVld = 0, ldVld = 0;
  logic [31:0] stAddr = '0, ldAddr = '0;
  logic [1:0]  stSize = '0, ldSize = '0;
  logic [5:0]  stId = '0, flushId = '0;
  logic        stReady, ldGrant, ldDeny;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;
  logic readyAtDrive;
  logic [5:0] nextId = '0;

  always #4 clk = ~clk;

  early_load_gate dut_i (
    .clk(clk), .rstN(rstN), .stVld(stVld), .stTracked(stTracked),
    .stAddr(stAddr), .stSize(stSize), .stId(stId), .stReady(stReady),
    .retireVld(retireVld), .flushVld(flushVld), .flushId(flushId),
    .ldVld(ldVld), .ldAddr(ldAddr), .ldSize(ldSize),
    .ldGrant(ldGrant), .ldDeny(ldDeny)
  );

  // Vector: {tag[3:0], stV, stT, stA[15:0], stS[1:0], ret, ldV, ldA[15:0], ldS[1:0], expDeny}
  localparam int NV = 17;
  function automatic logic [44:0] vec(input logic [3:0] tag, input logic sv, input logic st,
                                      input logic [15:0] sa, input logic [1:0] ss,
                                      input logic rt, input logic lv, input logic [15:0] la,
                                      input logic [1:0] ls, input logic ed);
    return {tag, sv, st, sa, ss, rt, lv, la, ls, ed};
  endfunction

  localparam logic [44:0] VECS [NV] = '{
    vec(4'd4,  0,0,16'h0000,0, 0, 1,16'h0100,2, 0),
    vec(4'd6,  1,1,16'h0100,2, 0, 1,16'h0100,2, 1),
    vec(4'd4,  0,0,16'h0000,0, 0, 1,16'h0104,2, 0),
    vec(4'd3,  0,0,16'h0000,0, 0, 1,16'h0103,0, 1),
    vec(4'd4,  0,0,16'h0000,0, 0, 1,16'h00FE,1, 0),
    vec(4'd3,  0,0,16'h0000,0, 0, 1,16'h00FF,1, 1),
    vec(4'd4,  1,1,16'h0200,3, 0, 1,16'h00F8,3, 0),
    vec(4'd3,  0,0,16'h0000,0, 0, 1,16'h0206,2, 1),
    vec(4'd10, 0,0,16'h0000,0, 1, 1,16'h0100,2, 1),
    vec(4'd7,  0,0,16'h0000,0, 0, 1,16'h0100,2, 0),
    vec(4'd5,  1,0,16'h0900,0, 0, 1,16'h0400,2, 1),
    vec(4'd5,  0,0,16'h0000,0, 0, 1,16'h0010,0, 1),
    vec(4'd2,  0,0,16'h0000,0, 1, 0,16'h0000,0, 0),
    vec(4'd5,  0,0,16'h0000,0, 0, 1,16'h0204,0, 1),
    vec(4'd2,  0,0,16'h0000,0, 1, 0,16'h0000,0, 0),
    vec(4'd7,  0,0,16'h0000,0, 0, 1,16'h0204,0, 0),
    vec(4'd7,  0,0,16'h0000,0, 1, 1,16'h0000,3, 0)
  };

  function automatic string tagName(input logic [3:0] n);
    case (n)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [1:0] act,
                     input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // Drive one cycle at posedge+2, return at the next posedge+2
  task automatic cyc(input logic sv, input logic st, input logic [31:0] sa,
                     input logic [1:0] ss, input logic [5:0] si, input logic rt,
                     input logic fl, input logic [5:0] fi, input logic lv,
                     input logic [31:0] la, input logic [1:0] ls);
    stVld = sv; stTracked = st; stAddr = sa; stSize = ss; stId = si;
    retireVld = rt; flushVld = fl; flushId = fi;
    ldVld = lv; ldAddr = la; ldSize = ls;
    #1 readyAtDrive = stReady;
    @(posedge clk);
    #2;
    stVld = 0; retireVld = 0; flushVld = 0; ldVld = 0;
  endtask

  task automatic query(input string tag, input logic [31:0] a, input logic [1:0] s,
                       input logic expDeny);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, a, s);
    chk(tag, $sformatf("load %h size %0d {grant,deny}", a, s), {ldGrant, ldDeny},
        {~expDeny, expDeny});
  endtask

  task automatic push(input logic tr, input logic [31:0] a, input logic [1:0] s,
                      input logic [5:0] id);
    cyc(1, tr, a, s, id, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state, sampled while still in reset and just after release
    chk("R1", "stReady in reset", {1'b0, stReady}, 2'b01);
    chk("R1", "responses in reset", {ldGrant, ldDeny}, 2'b00);
    rstN = 1'b1;
    @(posedge clk);
    #2;
    chk("R1", "stReady after reset", {1'b0, stReady}, 2'b01);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [44:0] w;
      logic [1:0]  exp;
      w = VECS[v];
      cyc(w[40], w[39], {16'h0, w[38:23]}, w[22:21], nextId, w[20], 0, 0,
          w[19], {16'h0, w[18:3]}, w[2:1]);
      if (w[40]) nextId++;
      exp = w[19] ? {~w[0], w[0]} : 2'b00;
      chk(tagName(w[44:41]), $sformatf("vector %0d {grant,deny}", v), {ldGrant, ldDeny}, exp);
    end

    // R9: fill to capacity
    begin
      logic [5:0] base;
      base = nextId;
      for (int i = 0; i < 8; i++) begin
        push(1, 32'h1000 + 32'(16 * i), 2, nextId);
        nextId++;
      end
      chk("R9", "stReady when full", {1'b0, stReady}, 2'b00);
      query("R9", 32'h1070, 2, 1);
      // Store presented while full is ignored, also for a same-cycle query
      cyc(1, 1, 32'h3000, 2, nextId, 0, 0, 0, 1, 32'h3000, 2);
      nextId++;
      chk("R9", "store while full not seen by query", {ldGrant, ldDeny}, 2'b10);
      cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
      chk("R9", "stReady after retire", {1'b0, stReady}, 2'b01);
      query("R9", 32'h3000, 2, 0);
      query("R7", 32'h1000, 2, 0);

      // R8: flush keeps ids up to base+3 (0x1030), drops 0x1040..0x1070
      cyc(1, 1, 32'h5000, 2, nextId, 0, 1, base + 6'd3, 0, 0, 0);
      nextId++;
      chk("R8", "stReady during flush", {1'b0, readyAtDrive}, 2'b00);
      query("R8", 32'h1040, 2, 0);
      query("R8", 32'h1070, 2, 0);
      query("R8", 32'h1030, 2, 1);
      query("R8", 32'h5000, 2, 0);
    end

    // Drain; extra retires on an empty queue are ignored (R7)
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R7", "stReady after drain", {1'b0, stReady}, 2'b01);
    query("R7", 32'h1010, 2, 0);

    // R8 wrap-around ids: 62, 63, 0, 1
    push(1, 32'h2000, 2, 6'd62);
    push(1, 32'h2010, 2, 6'd63);
    push(1, 32'h2020, 2, 6'd0);
    push(1, 32'h2030, 2, 6'd1);
    // R10: query in the flush cycle still sees the flushed store
    cyc(0, 0, 0, 0, 0, 0, 1, 6'd63, 1, 32'h2020, 2);
    chk("R10", "query during flush {grant,deny}", {ldGrant, ldDeny}, 2'b01);
    query("R8", 32'h2020, 2, 0);
    query("R8", 32'h2030, 2, 0);
    query("R8", 32'h2010, 2, 1);
    query("R8", 32'h2000, 2, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2", "no response without query", {ldGrant, ldDeny}, 2'b00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule